// File: doc/BRIEF.md
# Configurable DRAM Access Sequencer

This block turns single accesses from a simple bus master into DRAM strobe sequences. The address space it serves is split into four areas, picked by the top address bits. For each access the block decides whether the target area is DRAM or ordinary memory. For DRAM it then steps through a row phase, a column phase and a precharge state. It drives one active-low RAS pin per area, a shared CAS, an output-enable, select flags that say whether the multiplexed address bus carries the row or the column, and a ready pulse back to the master. An access to ordinary memory produces no DRAM strobes and is answered with a separate done pulse.

A six-bit configuration register sets the run-time behaviour:
- how many areas are DRAM, or whether all four form one continuous DRAM space served by a single RAS pin;
- whether the column phase lasts two or three states;
- whether consecutive accesses to an open row reuse it in fast page mode.

The register can only change while the sequencer is idle. The master starts an access by pulsing `start` with `req_addr` while `can_accept` is high.

Top module: `dram_seq_top`

## Requirements
- R1: After a synchronous reset: all RAS pins, CAS and OE are high (deasserted), both ack pulses are low, `can_accept` is 1 and `cfg_rdata` reads 0.
- R2: The register layout is: bit 0 selects the column phase length, bits 3:1 hold the space code, bit 4 enables fast page mode, and bit 5 is a spare bit. `cfg_rdata` returns all six bits exactly as last written.
- R3: Address bits [20:19] select the area: 0 is the first area, driving RAS pin 0, and so on up to 3. Space code 001 maps area 0 as DRAM, code 010 maps areas 0 and 1, and code 011 maps all four. Every other area is ordinary memory.
- R4: Space codes 100, 101 and 110 are reserved and give no DRAM at all. An access to ordinary memory, or any access under a reserved code, asserts no RAS or CAS and is answered by a one-cycle `ack_norm` pulse.
- R5: Space code 111 maps all four areas as one continuous DRAM space, and every access then drives RAS pin 0 only.
- R6: A DRAM access that opens a row proceeds as follows:
  - One row state with RAS low, CAS high, `row_sel` high and `mem_addr` = row (address bits [18:9]).
  - A column phase with CAS low, `col_sel` high and `mem_addr` = column (bits [8:0]). It lasts 2 states when bit 0 is 0 and 3 states when bit 0 is 1.
  - `ack_dram` is high in the last column state.
- R7: With fast page mode on, RAS stays low after the column phase. A following DRAM access to the same area and row repeats only the column phase, with no row state.
- R8: With fast page mode on, an access to a different row or area, or an ordinary-memory access, first raises RAS for one precharge state. A DRAM access then runs a new row state.
- R9: A register write is taken only while the sequencer is idle. A write while an access is running, or while a page is held open, leaves `cfg_rdata` unchanged.
- R10: OE is low in every column state and while a page is held open.
- R11: With fast page mode off, RAS is high again by the time `can_accept` returns. At most one RAS pin is low at a time, and CAS is never low without a RAS pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 6 | Register write data |
| cfg_rdata | output | 6 | Register contents |
| start | input | 1 | One-cycle access request |
| req_addr | input | 21 | Access address: area, row, column |
| can_accept | output | 1 | Sequencer can take `start` this cycle |
| ras_n | output | 4 | Active-low RAS, one per area |
| cas_n | output | 1 | Active-low CAS |
| oe_n | output | 1 | Active-low output enable |
| row_sel | output | 1 | Address bus carries the row |
| col_sel | output | 1 | Address bus carries the column |
| mem_addr | output | 10 | Multiplexed DRAM address |
| ack_dram | output | 1 | Ready pulse in last column state |
| ack_norm | output | 1 | Done pulse for ordinary-memory access |

## Verification
The bench issues accesses under each space code and under each column length, covering every area. This separates the per-area DRAM mapping, the reserved codes and the single-pin continuous mode by which RAS pin falls, if any.

With fast page mode on, a run of accesses mixes four cases:
- the same row twice;
- a new row in the same area;
- the same row in another area;
- an ordinary-memory access.

The presence or absence of a row state then tells a page hit from a miss that needs precharge. Register writes are attempted both while idle and while a page is held open, to show that writes are gated.

// File: rtl/dramseq_pkg.sv
package dramseq_pkg;
  localparam int CFG_W         = 6;
  localparam int CFG_COL3      = 0;
  localparam int CFG_SPACE_LSB = 1;
  localparam int CFG_SPACE_W   = 3;
  localparam int CFG_BURST     = 4;

  localparam logic [2:0] SP_ONE  = 3'b001;
  localparam logic [2:0] SP_TWO  = 3'b010;
  localparam logic [2:0] SP_ALL  = 3'b011;
  localparam logic [2:0] SP_CONT = 3'b111;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL1, S_COL2, S_COL3, S_PAGE, S_PRE, S_NORM
  } seq_state_t;
endpackage

// File: rtl/dramseq_cfg.sv
module dramseq_cfg
  import dramseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             idle,
  output logic [CFG_W-1:0] cfg_q,
  output logic             col3,
  output logic             burst,
  output logic [2:0]       space
);
  always_ff @(posedge clk) begin
    if (rst)
      cfg_q <= '0;
    else if (we && idle)
      cfg_q <= wdata;
  end

  assign col3  = cfg_q[CFG_COL3];
  assign burst = cfg_q[CFG_BURST];
  assign space = cfg_q[CFG_SPACE_LSB +: CFG_SPACE_W];
endmodule

// File: rtl/dramseq_decode.sv
module dramseq_decode
  import dramseq_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  parameter int AREA_W    = 2
) (
  input  logic [2:0]        space,
  input  logic [AREA_W-1:0] area,
  output logic              is_dram,
  output logic [AREA_W-1:0] pin
);
  logic [NUM_AREAS-1:0] mapped;

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
    always_comb begin
      unique case (space)
        SP_ONE:  mapped[i] = (i < 1);
        SP_TWO:  mapped[i] = (i < 2);
        SP_ALL:  mapped[i] = 1'b1;
        SP_CONT: mapped[i] = 1'b1;
        default: mapped[i] = 1'b0;
      endcase
    end
  end

  assign is_dram = mapped[area];
  assign pin     = (space == SP_CONT) ? '0 : area;
endmodule

// File: rtl/dramseq_fsm.sv
module dramseq_fsm
  import dramseq_pkg::*;
#(
  parameter int AREA_W = 2,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              col3,
  input  logic              burst,
  input  logic              new_dram,
  input  logic [AREA_W-1:0] new_area,
  input  logic [AREA_W-1:0] new_pin,
  input  logic [ROW_W-1:0]  new_row,
  input  logic [COL_W-1:0]  new_col,
  output logic              can_accept,
  output logic              idle,
  output seq_state_t        state_d,
  output logic [AREA_W-1:0] nxt_pin,
  output logic [ROW_W-1:0]  nxt_row,
  output logic [COL_W-1:0]  nxt_col
);
  seq_state_t        state_q;
  logic              pend_q;
  logic              cur_dram;
  logic [AREA_W-1:0] cur_area, cur_pin;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              accept, hit;

  assign can_accept = (state_q == S_IDLE) || (state_q == S_PAGE);
  assign idle       = (state_q == S_IDLE);
  assign accept     = start && can_accept;
  assign hit        = new_dram && (new_area == cur_area) && (new_row == cur_row);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = new_dram ? S_ROW : S_NORM;
      S_ROW:  state_d = S_COL1;
      S_COL1: state_d = S_COL2;
      S_COL2: state_d = col3 ? S_COL3 : (burst ? S_PAGE : S_PRE);
      S_COL3: state_d = burst ? S_PAGE : S_PRE;
      S_PAGE: if (start) state_d = hit ? S_COL1 : S_PRE;
      S_PRE:  state_d = pend_q ? (cur_dram ? S_ROW : S_NORM) : S_IDLE;
      S_NORM: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      pend_q   <= 1'b0;
      cur_dram <= 1'b0;
      cur_area <= '0;
      cur_pin  <= '0;
      cur_row  <= '0;
      cur_col  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        cur_dram <= new_dram;
        cur_area <= new_area;
        cur_pin  <= new_pin;
        cur_row  <= new_row;
        cur_col  <= new_col;
      end
      if (accept && state_q == S_PAGE && !hit)
        pend_q <= 1'b1;
      else if (state_q == S_PRE)
        pend_q <= 1'b0;
    end
  end

  assign nxt_pin = accept ? new_pin : cur_pin;
  assign nxt_row = accept ? new_row : cur_row;
  assign nxt_col = accept ? new_col : cur_col;
endmodule

// File: rtl/dramseq_outreg.sv
module dramseq_outreg
  import dramseq_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  parameter int AREA_W    = 2,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 9,
  parameter int MA_W      = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  seq_state_t           state_d,
  input  logic                 col3,
  input  logic [AREA_W-1:0]    nxt_pin,
  input  logic [ROW_W-1:0]     nxt_row,
  input  logic [COL_W-1:0]     nxt_col,
  output logic [NUM_AREAS-1:0] ras_n,
  output logic                 cas_n,
  output logic                 oe_n,
  output logic                 row_sel,
  output logic                 col_sel,
  output logic [MA_W-1:0]      mem_addr,
  output logic                 ack_dram,
  output logic                 ack_norm
);
  logic in_col, ras_on, last_col;

  assign in_col   = (state_d == S_COL1) || (state_d == S_COL2) || (state_d == S_COL3);
  assign ras_on   = in_col || (state_d == S_ROW) || (state_d == S_PAGE);
  assign last_col = (state_d == S_COL3) || ((state_d == S_COL2) && !col3);

  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_ras
    always_ff @(posedge clk) begin
      if (rst) ras_n[i] <= 1'b1;
      else     ras_n[i] <= !(ras_on && (nxt_pin == AREA_W'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_n    <= 1'b1;
      oe_n     <= 1'b1;
      row_sel  <= 1'b0;
      col_sel  <= 1'b0;
      mem_addr <= '0;
      ack_dram <= 1'b0;
      ack_norm <= 1'b0;
    end else begin
      cas_n    <= !in_col;
      oe_n     <= !(in_col || (state_d == S_PAGE));
      row_sel  <= (state_d == S_ROW);
      col_sel  <= in_col;
      ack_dram <= last_col;
      ack_norm <= (state_d == S_NORM);
      if (state_d == S_ROW)
        mem_addr <= MA_W'(nxt_row);
      else if (in_col)
        mem_addr <= MA_W'(nxt_col);
      else
        mem_addr <= '0;
    end
  end
endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top
  import dramseq_pkg::*;
#(
  parameter int NUM_AREAS = 4,
  parameter int ROW_W     = 10,
  parameter int COL_W     = 9,
  localparam int AREA_W   = (NUM_AREAS > 1) ? $clog2(NUM_AREAS) : 1,
  localparam int ADDR_W   = AREA_W + ROW_W + COL_W,
  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    req_addr,
  output logic                 can_accept,
  output logic [NUM_AREAS-1:0] ras_n,
  output logic                 cas_n,
  output logic                 oe_n,
  output logic                 row_sel,
  output logic                 col_sel,
  output logic [MA_W-1:0]      mem_addr,
  output logic                 ack_dram,
  output logic                 ack_norm
);
  logic              st_idle, col3, burst, new_dram;
  logic [2:0]        space;
  logic [AREA_W-1:0] new_area, new_pin, nxt_pin;
  logic [ROW_W-1:0]  new_row, nxt_row;
  logic [COL_W-1:0]  new_col, nxt_col;
  seq_state_t        state_d;

  assign new_area = req_addr[ADDR_W-1 -: AREA_W];
  assign new_row  = req_addr[COL_W +: ROW_W];
  assign new_col  = req_addr[COL_W-1:0];

  dramseq_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .idle(st_idle),
    .cfg_q(cfg_rdata), .col3(col3), .burst(burst), .space(space)
  );

  dramseq_decode #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W)) u_dec (
    .space(space), .area(new_area), .is_dram(new_dram), .pin(new_pin)
  );

  dramseq_fsm #(.AREA_W(AREA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .col3(col3), .burst(burst),
    .new_dram(new_dram), .new_area(new_area), .new_pin(new_pin),
    .new_row(new_row), .new_col(new_col), .can_accept(can_accept),
    .idle(st_idle), .state_d(state_d), .nxt_pin(nxt_pin),
    .nxt_row(nxt_row), .nxt_col(nxt_col)
  );

  dramseq_outreg #(.NUM_AREAS(NUM_AREAS), .AREA_W(AREA_W), .ROW_W(ROW_W),
                   .COL_W(COL_W), .MA_W(MA_W)) u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .col3(col3), .nxt_pin(nxt_pin),
    .nxt_row(nxt_row), .nxt_col(nxt_col), .ras_n(ras_n), .cas_n(cas_n),
    .oe_n(oe_n), .row_sel(row_sel), .col_sel(col_sel), .mem_addr(mem_addr),
    .ack_dram(ack_dram), .ack_norm(ack_norm)
  );
endmodule

// File: rtl/dramseq_chk.sv
module dramseq_chk #(
  parameter int NUM_AREAS = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_AREAS-1:0] ras_n,
  input logic                 cas_n,
  input logic                 oe_n,
  input logic                 row_sel,
  input logic                 col_sel,
  input logic                 ack_dram,
  input logic                 ack_norm,
  input logic [5:0]           cfg_rdata,
  input logic                 idle
);
  logic [2:0] space;
  assign space = cfg_rdata[3:1];

  assert_one_ras_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ras_n));
  assert_cas_needs_ras_R11: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !(&ras_n));
  assert_ack_in_col_R6: assert property (@(posedge clk) disable iff (rst)
    ack_dram |-> (!cas_n && col_sel && !ack_norm));
  assert_row_phase_R6: assert property (@(posedge clk) disable iff (rst)
    row_sel |-> (!(&ras_n) && cas_n && !col_sel));
  assert_norm_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    ack_norm |-> ((&ras_n) && cas_n));
  assert_resv_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (space == 3'b100 || space == 3'b101 || space == 3'b110) |-> ((&ras_n) && cas_n));
  assert_cont_pin0_R5: assert property (@(posedge clk) disable iff (rst)
    (space == 3'b111) |-> (&ras_n[NUM_AREAS-1:1]));
  assert_oe_in_col_R10: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !oe_n);
  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(cfg_rdata));
endmodule

bind dram_seq_top dramseq_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
  .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .row_sel(row_sel), .col_sel(col_sel), .ack_dram(ack_dram),
  .ack_norm(ack_norm), .cfg_rdata(cfg_rdata), .idle(st_idle)
);

// File: tb/tb_dram_seq_top.sv
module tb_dram_seq_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [5:0]  cfg_wdata = '0;
  logic [5:0]  cfg_rdata;
  logic        start = 0;
  logic [20:0] req_addr = '0;
  logic        can_accept;
  logic [3:0]  ras_n;
  logic        cas_n, oe_n, row_sel, col_sel, ack_dram, ack_norm;
  logic [9:0]  mem_addr;

  always #10 clk = ~clk;

  dram_seq_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start(start), .req_addr(req_addr),
    .can_accept(can_accept), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
    .row_sel(row_sel), .col_sel(col_sel), .mem_addr(mem_addr),
    .ack_dram(ack_dram), .ack_norm(ack_norm)
  );

  typedef struct packed {
    logic       dram;
    logic       saw_row;
    logic [1:0] pin;
    logic [9:0] row;
    logic [8:0] col;
    logic [1:0] ncas;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [5:0] cfg_m = '0;
  logic       page_open = 0;
  logic [1:0] open_area = '0;
  logic [9:0] open_row = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] mk(input int area, input int row, input int col);
    return {area[1:0], row[9:0], col[8:0]};
  endfunction

  task automatic wr_cfg(input logic [5:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_accept();
    @(negedge clk);
    while (!can_accept) @(negedge clk);
  endtask

  // driver: model the expected outcome and push it to the scoreboard
  task automatic access(input logic [20:0] a);
    exp_t e;
    logic [2:0] sp;
    logic [1:0] area;
    logic dram, hit;
    wait_accept();
    sp   = cfg_m[3:1];
    area = a[20:19];
    case (sp)
      3'b001:         dram = (area == 0);
      3'b010:         dram = (area <= 1);
      3'b011, 3'b111: dram = 1;
      default:        dram = 0;
    endcase
    hit = cfg_m[4] && dram && page_open && area == open_area && a[18:9] == open_row;
    e.dram    = dram;
    e.saw_row = dram && !hit;
    e.pin     = (sp == 3'b111) ? 2'd0 : area;
    e.row     = a[18:9];
    e.col     = a[8:0];
    e.ncas    = dram ? (cfg_m[0] ? 2'd3 : 2'd2) : 2'd0;
    if (dram) begin
      page_open = cfg_m[4]; open_area = area; open_row = a[18:9];
    end else page_open = 0;
    exp_q.push_back(e);
    start = 1; req_addr = a;
    @(negedge clk);
    start = 0;
  endtask

  // monitor: accumulate what the pins showed, compare on each ack
  logic       m_row_seen = 0, m_oe_bad = 0;
  logic [9:0] m_row = '0, m_col = '0;
  int         m_ncas = 0, m_pin = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (row_sel) begin m_row_seen = 1; m_row = mem_addr; end
      if (!cas_n) begin
        m_ncas++; m_col = mem_addr;
        if (oe_n) m_oe_bad = 1;
        for (int i = 0; i < 4; i++) if (!ras_n[i]) m_pin = i;
      end
      if (ack_dram || ack_norm) begin
        if (exp_q.size() == 0) chk("R6 unexpected ack", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R3/R4 access kind dram", int'(ack_dram), int'(e.dram));
          chk("R7/R8 row phase present", int'(m_row_seen), int'(e.saw_row));
          chk("R6 CAS state count", m_ncas, int'(e.ncas));
          if (e.dram) begin
            chk("R3/R5 RAS pin", m_pin, int'(e.pin));
            chk("R6 column on bus", int'(m_col), int'(e.col));
            if (e.saw_row) chk("R6 row on bus", int'(m_row), int'(e.row));
            chk("R10 OE in column", int'(m_oe_bad), 0);
          end else begin
            chk("R4 no RAS on normal", int'(ras_n), 15);
          end
        end
        m_row_seen = 0; m_oe_bad = 0; m_ncas = 0; m_pin = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_cfg(input logic [5:0] v);
    wait_accept();
    wr_cfg(v);
    cfg_m = v;
    page_open = 0;
    @(negedge clk);
    chk("R2 register readback", int'(cfg_rdata), int'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ras_n at reset", int'(ras_n), 15);
    chk("R1 cas_n/oe_n at reset", int'({cas_n, oe_n}), 3);
    chk("R1 acks at reset", int'({ack_dram, ack_norm}), 0);
    chk("R1 cfg at reset", int'(cfg_rdata), 0);
    chk("R1 can_accept at reset", int'(can_accept), 1);

    // R2 spare bit reads back
    set_cfg(6'b100000);
    access(mk(0, 5, 7));              // code 000: normal
    // R3 one area mapped, R11 precharge with burst off
    set_cfg(6'b000010);
    access(mk(0, 12, 34));
    access(mk(1, 12, 34));            // normal
    access(mk(0, 100, 200));
    wait_accept();
    chk("R11 RAS high when accept returns", int'(ras_n), 15);
    // two areas, 3-state column
    set_cfg(6'b000101);
    access(mk(1, 777, 300));
    access(mk(2, 1, 1));              // normal
    // all four areas
    set_cfg(6'b000110);
    access(mk(3, 1023, 511));
    access(mk(2, 0, 0));
    // reserved codes R4
    set_cfg(6'b001000); access(mk(0, 3, 3));
    set_cfg(6'b001010); access(mk(1, 3, 3));
    set_cfg(6'b001100); access(mk(0, 3, 3));
    // continuous R5
    set_cfg(6'b001111);
    access(mk(3, 40, 41));
    access(mk(1, 42, 43));
    // fast page R7/R8/R9/R10: areas 0,1 DRAM, burst on
    set_cfg(6'b010100);
    access(mk(0, 50, 1));
    wait_accept();
    @(negedge clk);
    chk("R7 RAS held open", int'(ras_n), 14);
    chk("R10 OE low while page open", int'(oe_n), 0);
    chk("R7 CAS high between", int'(cas_n), 1);
    wr_cfg(6'b000000);
    @(negedge clk);
    chk("R9 write ignored while page open", int'(cfg_rdata), 6'b010100);
    access(mk(0, 50, 2));             // hit
    access(mk(0, 50, 3));             // hit
    access(mk(0, 51, 4));             // row miss
    access(mk(1, 51, 5));             // area change
    access(mk(2, 51, 6));             // normal closes page
    // continuous with burst: area change is a miss even on pin 0
    set_cfg(6'b011111);
    access(mk(2, 9, 9));
    access(mk(2, 9, 10));             // hit
    access(mk(3, 9, 11));             // miss
    wait_accept();
    repeat (10) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule